// File: doc/BRIEF.md
# Dot-Matrix LCD Scan Timing Generator

This block drives the column and row drivers of a dot-matrix liquid crystal panel from bytes held in a display memory. The panel is split into an upper and a lower half. Both halves are scanned at the same time, and each half has its own serial data line. Every memory bit becomes one dot, and a 1 turns the dot on. The block makes the shift clock that moves dots into the column drivers. It also makes a latch pulse that commits each finished row, a frame marker for the row drivers, and a polarity-alternation signal that keeps DC off the liquid crystal.

The block reads memory through a simple fetch port. It drives an address and a read strobe, and expects the byte one clock later. Two internal address counters walk the memory. One starts at the programmed base address for the upper half. The other starts at the base plus rows times bytes-per-row for the lower half. The bytes per row and the number of rows per half are programmable. The rows per half run from 1 (static drive) to 2^ROW_W (1/128 duty at the default width). A slot is one byte time, 2*DATA_W clocks. Each row takes one latch slot followed by one data slot per byte.

The register enable input works as the display on/off control. While it is low, every output stays idle. Parameters set the byte width, the address width, the counter widths, the latch pulse length and the bit order.

Top module: `lcd_scan_timer`

## Requirements
- R1: While `en` is low, and after reset, all outputs are low. This covers `lcd_sclk`, `lcd_latch`, `lcd_frame`, `lcd_ac`, both data lines, `rd_en` and `rd_addr`.
- R2: With H bytes per row, R rows per half and base B, the fetch for byte s of row r works as follows, with addresses taken modulo 2^ADDR_W:
  - In slot s (s from 0 to H-1), clock 0 of the slot drives `rd_en` high with `rd_addr` = B + r*H + s, the upper-half byte.
  - Clock 1 of the slot drives `rd_en` high with `rd_addr` = B + (R+r)*H + s, the lower-half byte.
  - `rd_en` is low at all other times.
- R3: Byte s of a row is shifted out in slot s+1, least significant bit first.
  - Bit k is held on the data line during clocks 2k and 2k+1 of that slot.
  - `lcd_d_upper` carries the upper-half byte and `lcd_d_lower` carries the lower-half byte.
  - Both data lines are 0 in the latch slot.
- R4: `lcd_sclk` is high on the odd clocks of each data slot and low everywhere else. This gives exactly 8*H rising edges per row at DATA_W=8.
- R5: Each row starts with a latch slot. `lcd_latch` is high for the first LATCH_LEN clocks of that slot and is never high at the same time as `lcd_sclk`. A row lasts (H+1)*2*DATA_W clocks.
- R6: `lcd_frame` is high exactly when `lcd_latch` is high during row 0 of a frame.
- R7: A frame lasts R rows. `lcd_ac` is 0 throughout the first frame after enable and inverts at the first clock of each later frame.
- R8: The row length, the rows per half and the base address are sampled only when the display is enabled and at each frame boundary. A change in the middle of a frame has no effect until the next frame.
- R9: Static drive (one row per half) is supported. Every row is then row 0, so `lcd_frame` comes with every latch pulse and `lcd_ac` inverts every row after the first.
- R10: Dropping `en` makes every output idle from the next clock. Raising `en` again restarts at row 0, slot 0, with `lcd_ac` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Display on; low holds all outputs idle |
| cfg_hbytes_m1 | input | HB_W | Bytes per row minus one |
| cfg_rows_m1 | input | ROW_W | Rows per half minus one (0 = static) |
| cfg_base | input | ADDR_W | Display memory start address |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | ADDR_W | Memory read address (0 when idle) |
| rd_data | input | DATA_W | Read data, valid one clock after the strobe |
| lcd_d_upper | output | 1 | Serial dots for the upper half |
| lcd_d_lower | output | 1 | Serial dots for the lower half |
| lcd_sclk | output | 1 | Column driver shift clock |
| lcd_latch | output | 1 | Row latch pulse |
| lcd_frame | output | 1 | Frame marker |
| lcd_ac | output | 1 | Drive polarity alternation |

## Verification
A wrong slot or clock counter changes the position or the count of `lcd_sclk` edges and latch pulses within one row period. A wrong row counter or polarity bit shows as a misplaced `lcd_frame` or `lcd_ac` edge at the next frame boundary. An address counter that slips shows on `rd_addr` at the very next fetch clock, and shows as wrong dots on a data line one slot later. The bench therefore compares every output on every clock against a position-based model, so that any error is caught on the clock where it first appears.

// File: rtl/lcdtg_pkg.sv
package lcdtg_pkg;

   // Each bit takes a low phase (data set up) and a high phase (clock rises).
   localparam int unsigned CLK_PER_BIT = 2;

   function automatic int unsigned slot_len(input int unsigned data_w);
      return CLK_PER_BIT * data_w;
   endfunction

   function automatic int unsigned cyc_width(input int unsigned data_w);
      return $clog2(CLK_PER_BIT * data_w);
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/lcdtg_scan_ctr.sv
module lcdtg_scan_ctr
   import lcdtg_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned HB_W   = 6,
   parameter int unsigned ROW_W  = 7,
   localparam int unsigned CYC_W = cyc_width(DATA_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [HB_W-1:0]  cfg_hbytes_m1,
   input  logic [ROW_W-1:0] cfg_rows_m1,
   output logic             running,
   output logic             load_cfg,
   output logic [CYC_W-1:0] cyc,
   output logic [HB_W:0]    slot,
   output logic [ROW_W-1:0] row,
   output logic [HB_W-1:0]  hb_m1,
   output logic             ac
);

   localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(slot_len(DATA_W) - 1);

   logic [ROW_W-1:0] rows_m1;
   logic             last_cyc;
   logic             last_slot;
   logic             last_row;
   logic             frame_wrap;

   assign last_cyc   = (cyc == CYC_LAST);
   assign last_slot  = (slot == ({1'b0, hb_m1} + 1'b1));
   assign last_row   = (row == rows_m1);
   assign frame_wrap = running && last_cyc && last_slot && last_row;
   assign load_cfg   = en && (!running || frame_wrap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cyc     <= '0;
         slot    <= '0;
         row     <= '0;
         ac      <= 1'b0;
         hb_m1   <= '0;
         rows_m1 <= '0;
      end else if (!en) begin
         running <= 1'b0;
         cyc     <= '0;
         slot    <= '0;
         row     <= '0;
         ac      <= 1'b0;
      end else begin
         running <= 1'b1;
         if (load_cfg) begin
            hb_m1   <= cfg_hbytes_m1;
            rows_m1 <= cfg_rows_m1;
         end
         if (running) begin
            if (last_cyc) begin
               cyc <= '0;
               if (last_slot) begin
                  slot <= '0;
                  if (last_row) begin
                     row <= '0;
                     ac  <= ~ac;
                  end else begin
                     row <= row + 1'b1;
                  end
               end else begin
                  slot <= slot + 1'b1;
               end
            end else begin
               cyc <= cyc + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/lcdtg_fetch.sv
module lcdtg_fetch
   import lcdtg_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned HB_W   = 6,
   parameter int unsigned ROW_W  = 7,
   localparam int unsigned CYC_W = cyc_width(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              running,
   input  logic              load_cfg,
   input  logic [CYC_W-1:0]  cyc,
   input  logic [HB_W:0]     slot,
   input  logic [HB_W-1:0]   hb_m1,
   input  logic [HB_W-1:0]   cfg_hbytes_m1,
   input  logic [ROW_W-1:0]  cfg_rows_m1,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [DATA_W-1:0] rd_data,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] hold_up,
   output logic [DATA_W-1:0] hold_lo
);

   localparam int unsigned PROD_W = HB_W + ROW_W + 2;
   localparam logic [CYC_W-1:0] C_UP  = CYC_W'(0);
   localparam logic [CYC_W-1:0] C_LO  = CYC_W'(1);
   localparam logic [CYC_W-1:0] C_CAP = CYC_W'(2);

   logic [ADDR_W-1:0] up_addr;
   logic [ADDR_W-1:0] lo_addr;
   logic [ADDR_W-1:0] lo_start;
   logic [PROD_W-1:0] half_size;
   logic [HB_W:0]     hb_cnt;
   logic [ROW_W:0]    row_cnt;
   logic              fetch_slot;

   assign hb_cnt     = {1'b0, cfg_hbytes_m1} + 1'b1;
   assign row_cnt    = {1'b0, cfg_rows_m1} + 1'b1;
   assign half_size  = PROD_W'(hb_cnt) * PROD_W'(row_cnt);
   assign lo_start   = cfg_base + ADDR_W'(half_size);

   assign fetch_slot = running && (slot <= {1'b0, hb_m1});
   assign rd_en      = fetch_slot && ((cyc == C_UP) || (cyc == C_LO));
   assign rd_addr    = !rd_en ? '0 : ((cyc == C_LO) ? lo_addr : up_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_addr <= '0;
         lo_addr <= '0;
         hold_up <= '0;
         hold_lo <= '0;
      end else begin
         if (load_cfg) begin
            up_addr <= cfg_base;
            lo_addr <= lo_start;
         end else if (rd_en) begin
            if (cyc == C_UP) up_addr <= up_addr + 1'b1;
            else             lo_addr <= lo_addr + 1'b1;
         end
         // Read data arrives one clock after each strobe.
         if (fetch_slot && (cyc == C_LO))  hold_up <= rd_data;
         if (fetch_slot && (cyc == C_CAP)) hold_lo <= rd_data;
      end
   end

endmodule

// File: rtl/lcdtg_shifter.sv
module lcdtg_shifter #(
   parameter int unsigned DATA_W    = 8,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic [DATA_W-1:0] din,
   output logic              dout
);

   logic [DATA_W-1:0] sh;
   logic [DATA_W-1:0] sh_next;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign dout    = sh[0];
         assign sh_next = {1'b0, sh[DATA_W-1:1]};
      end else begin : g_msb
         assign dout    = sh[DATA_W-1];
         assign sh_next = {sh[DATA_W-2:0], 1'b0};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh <= '0;
      else if (load)  sh <= din;
      else if (shift) sh <= sh_next;
   end

endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
   import lcdtg_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned HB_W      = 6,
   parameter int unsigned ROW_W     = 7,
   parameter int unsigned LATCH_LEN = 8,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [HB_W-1:0]   cfg_hbytes_m1,
   input  logic [ROW_W-1:0]  cfg_rows_m1,
   input  logic [ADDR_W-1:0] cfg_base,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              lcd_d_upper,
   output logic              lcd_d_lower,
   output logic              lcd_sclk,
   output logic              lcd_latch,
   output logic              lcd_frame,
   output logic              lcd_ac
);

   localparam int unsigned CYC_W = cyc_width(DATA_W);
   localparam int unsigned NLANE = 2;
   localparam logic [CYC_W-1:0] CYC_LAST  = CYC_W'(slot_len(DATA_W) - 1);
   localparam logic [CYC_W-1:0] LATCH_END = CYC_W'(LATCH_LEN - 1);

   // Elaboration-time parameter checks.
   if (DATA_W < 2 || !is_pow2(DATA_W)) begin : g_bad_data_w
      $error("DATA_W must be a power of two, at least 2");
   end
   if (LATCH_LEN < 1 || LATCH_LEN > slot_len(DATA_W)) begin : g_bad_latch
      $error("LATCH_LEN must lie within one slot");
   end
   if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr_w
      $error("ADDR_W out of range");
   end
   if (HB_W < 1 || ROW_W < 1) begin : g_bad_cnt_w
      $error("counter widths must be at least 1");
   end

   logic             running;
   logic             load_cfg;
   logic [CYC_W-1:0] cyc;
   logic [HB_W:0]    slot;
   logic [ROW_W-1:0] row;
   logic [HB_W-1:0]  hb_m1;
   logic             ac;
   logic [DATA_W-1:0] hold [NLANE];
   logic [NLANE-1:0]  lane_bit;
   logic              sh_load;
   logic              sh_shift;
   logic              data_ph;

   lcdtg_scan_ctr #(
      .DATA_W (DATA_W),
      .HB_W   (HB_W),
      .ROW_W  (ROW_W)
   ) u_scan (
      .clk           (clk),
      .rst_n         (rst_n),
      .en            (en),
      .cfg_hbytes_m1 (cfg_hbytes_m1),
      .cfg_rows_m1   (cfg_rows_m1),
      .running       (running),
      .load_cfg      (load_cfg),
      .cyc           (cyc),
      .slot          (slot),
      .row           (row),
      .hb_m1         (hb_m1),
      .ac            (ac)
   );

   lcdtg_fetch #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .HB_W   (HB_W),
      .ROW_W  (ROW_W)
   ) u_fetch (
      .clk           (clk),
      .rst_n         (rst_n),
      .running       (running),
      .load_cfg      (load_cfg),
      .cyc           (cyc),
      .slot          (slot),
      .hb_m1         (hb_m1),
      .cfg_hbytes_m1 (cfg_hbytes_m1),
      .cfg_rows_m1   (cfg_rows_m1),
      .cfg_base      (cfg_base),
      .rd_data       (rd_data),
      .rd_en         (rd_en),
      .rd_addr       (rd_addr),
      .hold_up       (hold[0]),
      .hold_lo       (hold[1])
   );

   assign data_ph  = running && (slot != '0);
   assign sh_load  = running && (cyc == CYC_LAST) && (slot <= {1'b0, hb_m1});
   assign sh_shift = data_ph && cyc[0];

   for (genvar i = 0; i < NLANE; i++) begin : g_lane
      lcdtg_shifter #(
         .DATA_W    (DATA_W),
         .LSB_FIRST (LSB_FIRST)
      ) u_sh (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (sh_load),
         .shift (sh_shift),
         .din   (hold[i]),
         .dout  (lane_bit[i])
      );
   end

   assign lcd_d_upper = data_ph && lane_bit[0];
   assign lcd_d_lower = data_ph && lane_bit[1];
   assign lcd_sclk    = data_ph && cyc[0];
   assign lcd_latch   = running && (slot == '0) && (cyc <= LATCH_END);
   assign lcd_frame   = lcd_latch && (row == '0);
   assign lcd_ac      = ac;

endmodule

// File: rtl/lcd_scan_timer_chk.sv
module lcd_scan_timer_chk #(
   parameter int unsigned LATCH_LEN = 8
) (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic rd_en,
   input logic lcd_d_upper,
   input logic lcd_d_lower,
   input logic lcd_sclk,
   input logic lcd_latch,
   input logic lcd_frame,
   input logic lcd_ac
);

   logic        en_q;
   logic [15:0] lat_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         lat_run <= '0;
      end else begin
         en_q    <= en;
         lat_run <= lcd_latch ? lat_run + 1'b1 : '0;
      end
   end

   // R1 / R10: no activity unless enabled on the previous edge
   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !(lcd_sclk || lcd_latch || lcd_frame || lcd_ac || rd_en ||
                  lcd_d_upper || lcd_d_lower));

   // R2: strobes come in adjacent pairs
   p_fetch_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_en) |=> rd_en);
   p_fetch_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && $past(rd_en)) |=> !rd_en);

   // R3: data stays put across the shift clock rise
   p_data_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lcd_sclk) |-> ($stable(lcd_d_upper) && $stable(lcd_d_lower)));

   // R5: latch and shift clock never overlap, and the latch run is bounded
   p_latch_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_latch |-> !lcd_sclk);
   p_latch_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lat_run <= 16'(LATCH_LEN));

   // R6: frame marker only inside a latch pulse
   p_frame_in_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_frame |-> lcd_latch);

   // R7: polarity changes only as a frame begins
   p_ac_at_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && $past(en_q) && !$stable(lcd_ac)) |-> lcd_frame);

endmodule

bind lcd_scan_timer lcd_scan_timer_chk #(.LATCH_LEN(LATCH_LEN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en          (en),
   .rd_en       (rd_en),
   .lcd_d_upper (lcd_d_upper),
   .lcd_d_lower (lcd_d_lower),
   .lcd_sclk    (lcd_sclk),
   .lcd_latch   (lcd_latch),
   .lcd_frame   (lcd_frame),
   .lcd_ac      (lcd_ac)
);

// File: tb/tb_lcd_scan_timer.sv
module tb_lcd_scan_timer;

   localparam int AW = 12;
   localparam int DW = 8;
   localparam int SL = 2 * DW;
   localparam int LL = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic [5:0]    cfg_hbytes_m1 = '0;
   logic [6:0]    cfg_rows_m1 = '0;
   logic [AW-1:0] cfg_base = '0;
   logic          rd_en;
   logic [AW-1:0] rd_addr;
   logic [DW-1:0] rd_data = '0;
   logic          lcd_d_upper, lcd_d_lower, lcd_sclk, lcd_latch, lcd_frame, lcd_ac;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct packed {
      logic          sclk;
      logic          latch;
      logic          frm;
      logic          ac;
      logic          dup;
      logic          dlo;
      logic          rden;
      logic [AW-1:0] addr;
   } exp_t;

   always #10 clk = ~clk;

   lcd_scan_timer #(.DATA_W(DW), .ADDR_W(AW), .HB_W(6), .ROW_W(7),
                    .LATCH_LEN(LL), .LSB_FIRST(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .en(en),
      .cfg_hbytes_m1(cfg_hbytes_m1), .cfg_rows_m1(cfg_rows_m1), .cfg_base(cfg_base),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .lcd_d_upper(lcd_d_upper), .lcd_d_lower(lcd_d_lower), .lcd_sclk(lcd_sclk),
      .lcd_latch(lcd_latch), .lcd_frame(lcd_frame), .lcd_ac(lcd_ac)
   );

   function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
      return DW'(a * 29 + (a >> 3) + 12'h5A);
   endfunction

   // Display memory model with one clock of read latency.
   always @(posedge clk) if (rd_en) rd_data <= memf(rd_addr);

   function automatic exp_t model(input int t, input int ha, input int ra, input int ba,
                                  input int hb, input int rb, input int bb);
      exp_t e;
      int la, lb, f, h, r, b, rem, row, rr, s, c;
      logic [DW-1:0] bu, bl;
      la = ra * (ha + 1) * SL;
      if (t < la) begin
         f = 0; h = ha; r = ra; b = ba; rem = t;
      end else begin
         lb = rb * (hb + 1) * SL;
         f = 1 + (t - la) / lb; h = hb; r = rb; b = bb; rem = (t - la) % lb;
      end
      row = rem / ((h + 1) * SL);
      rr  = rem % ((h + 1) * SL);
      s   = rr / SL;
      c   = rr % SL;
      e.sclk  = (s > 0) && (c % 2 == 1);
      e.latch = (s == 0) && (c < LL);
      e.frm   = e.latch && (row == 0);
      e.ac    = f[0];
      e.dup   = 1'b0;
      e.dlo   = 1'b0;
      if (s > 0) begin
         bu = memf(AW'(b + row * h + s - 1));
         bl = memf(AW'(b + (r + row) * h + s - 1));
         e.dup = bu[c / 2];
         e.dlo = bl[c / 2];
      end
      e.rden = (s < h) && (c < 2);
      e.addr = !e.rden ? '0 : ((c == 0) ? AW'(b + row * h + s) : AW'(b + (r + row) * h + s));
      return e;
   endfunction

   task automatic chk(input string tag, input string what, input int got, input int exp);
      if (got != exp) begin
         fails++;
         if (fails < 25) $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   task automatic compare(input string sc, input exp_t e);
      checks++;
      chk("R4", {sc, " sclk"},  lcd_sclk,    e.sclk);
      chk("R5", {sc, " latch"}, lcd_latch,   e.latch);
      chk("R6", {sc, " frame"}, lcd_frame,   e.frm);
      chk("R7", {sc, " ac"},    lcd_ac,      e.ac);
      chk("R3", {sc, " d_up"},  lcd_d_upper, e.dup);
      chk("R3", {sc, " d_lo"},  lcd_d_lower, e.dlo);
      chk("R2", {sc, " rd_en"}, rd_en,       e.rden);
      chk("R2", {sc, " addr"},  rd_addr,     e.addr);
   endtask

   task automatic check_idle(input string tag, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         checks++;
         chk(tag, "idle outputs",
             {lcd_sclk, lcd_latch, lcd_frame, lcd_ac, lcd_d_upper, lcd_d_lower, rd_en},
             0);
         chk(tag, "idle rd_addr", rd_addr, 0);
      end
   endtask

   // Enable with config A, switch to config B after chg_at cycles, compare n cycles.
   task automatic run_scan(input string sc, input int ha, input int ra, input int ba,
                           input int hb, input int rb, input int bb,
                           input int chg_at, input int n, input bit stop);
      @(negedge clk);
      cfg_hbytes_m1 = 6'(ha - 1);
      cfg_rows_m1   = 7'(ra - 1);
      cfg_base      = AW'(ba);
      en = 1'b1;
      for (int t = 0; t < n; t++) begin
         @(negedge clk);
         compare(sc, model(t, ha, ra, ba, hb, rb, bb));
         if (t == chg_at) begin
            cfg_hbytes_m1 = 6'(hb - 1);
            cfg_rows_m1   = 7'(rb - 1);
            cfg_base      = AW'(bb);
         end
      end
      if (stop) begin
         en = 1'b0;
         check_idle("R10", 2);
      end
   endtask

   task automatic t_reset;      // R1
      check_idle("R1", 4);
      rst_n = 1'b1;
      cfg_hbytes_m1 = 6'd3; cfg_rows_m1 = 7'd5; cfg_base = 12'h123;
      check_idle("R1", 20);
   endtask

   task automatic t_basic;      // R2 R3 R4 R5 R6 R7
      run_scan("R3 basic", 3, 4, 16, 3, 4, 16, -1, 640, 1'b1);
   endtask

   task automatic t_static;     // R9
      run_scan("R9 static", 2, 1, 100, 2, 1, 100, -1, 200, 1'b1);
   endtask

   task automatic t_wrap;       // R2 address wrap at maximum duty
      run_scan("R2 wrap", 1, 128, 4090, 1, 128, 4090, -1, 8300, 1'b1);
   endtask

   task automatic t_cfgchg;     // R8
      run_scan("R8 cfgchg", 2, 3, 0, 4, 2, 200, 40, 544, 1'b1);
   endtask

   task automatic t_disable;    // R10
      run_scan("R10 pre", 2, 2, 7, 2, 2, 7, -1, 70, 1'b0);
      en = 1'b0;
      check_idle("R10", 5);
      run_scan("R10 restart", 2, 2, 7, 2, 2, 7, -1, 200, 1'b1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_basic();
      t_static();
      t_wrap();
      t_cfgchg();
      t_disable();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule